// File: doc/BRIEF.md
# I2C Target Receiver with Bus-Idle Timeout

This block is the target side of an I2C link. It watches already-synchronized SCL and SDA lines and finds START and STOP conditions. It shifts in a 7-bit address and answers a match with an acknowledge. After that it either takes in data bytes or sends bytes back. Both lines are driven only through open-drain enables: an enable at 1 pulls the line low. Received bytes go into a two-entry buffer. Host logic reads that buffer through a pop strobe, and supplies each outgoing byte through a valid strobe.

The block also keeps a bus busy/idle status. A programmable timeout counts clock cycles during which both lines stay high while the bus is busy. When the timeout expires, the block raises a sticky flag and marks the bus idle. It can also drop the receiver back to its idle state. Several races have a defined winner: a START arriving in the same cycle as an expiry, SDA moving between START and the first SCL rise, a buffer read landing in the same cycle as a buffer write, and arbitration loss while the block is sending. The host can also abort a transfer or toggle the enable. Both of these free the lines.

Top module: `i2ct_target`

## Requirements
- R1: A START (SDA falling while SCL stays high) sets `bus_busy`. A STOP (SDA rising while SCL stays high) clears it. Both are false after reset.
- R2: With `cfg_timeout` = L > 0, the timeout expires when the bus is busy and both lines have been high without any line edge for L consecutive clock cycles. Expiry sets `flag_timeout` and clears `bus_busy`. Any line edge restarts the count. After `flag_clr`, a later idle stretch on a busy bus fires again.
- R3: If a START is seen in the same cycle the timeout would expire, the START wins. `bus_busy` stays 1 and `flag_timeout` is not set.
- R4: With `cfg_go_idle` = 1, an expiry also forces the receiver idle. The remaining bits of that transfer are neither acknowledged nor stored. With `cfg_go_idle` = 0, the transfer carries on.
- R5: The first byte after START is the address, MSB first: 7 address bits, then the R/W bit (1 = read). On a match with `cfg_addr`, SDA is pulled low for the 9th SCL clock. On a mismatch it is not. Bit counting starts at the first SCL rise after START, so SDA moving while SCL is low before that rise does not shift the byte or the ACK slot.
- R6: In a write transfer, each data byte is stored MSB first and acknowledged in its 9th clock while buffer space is available.
- R7: The receive buffer holds 2 bytes in arrival order. `rx_valid` = 1 means at least one byte is present. `rx_full` = 1 means both entries are used. `rx_data` shows the oldest byte, and `rx_pop` removes it.
- R8: A pop in the same cycle as a byte write keeps the new byte. The byte count is unchanged, and `rx_full` = 1 with `rx_valid` = 0 never appears.
- R9: While the buffer is full and no pop occurs, a new byte is discarded and answered with NACK (SDA released).
- R10: In a read transfer, the block holds SCL low after each acknowledged byte slot until `tx_valid` supplies a byte. It then releases SCL and sends the byte MSB first. A master NACK ends the transfer.
- R11: If the block releases SDA to send a 1 and sees SDA low at the SCL rise, it sets `flag_arblost`, releases both lines and goes idle.
- R12: `cmd_abort` drops the current transfer and releases both lines on the next cycle.
- R13: `cfg_en` = 0 releases both lines and holds the receiver idle. After re-enable, or after any new START, the receiver restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_en | input | 1 | Receiver enable |
| cfg_addr | input | 7 | Own 7-bit address |
| cfg_timeout | input | TO_W | Idle timeout in cycles, 0 disables |
| cfg_go_idle | input | 1 | Expiry also forces receiver idle |
| cmd_abort | input | 1 | Abort strobe |
| flag_clr | input | 1 | Clears both sticky flags |
| tx_valid | input | 1 | Outgoing byte strobe |
| tx_data | input | 8 | Outgoing byte |
| rx_pop | input | 1 | Remove oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | At least one byte buffered |
| rx_full | output | 1 | Both entries used |
| bus_busy | output | 1 | Bus busy status |
| flag_timeout | output | 1 | Sticky timeout flag |
| flag_arblost | output | 1 | Sticky arbitration-lost flag |

## Verification
The bench makes a START land in exactly the cycle of expiry. A design that let the expiry through would set the timeout flag and report an idle bus in the middle of a transfer. It wiggles SDA while SCL is low before the first address clock. A counter started at START rather than at the first rise would put the acknowledge one clock early and store a shifted byte. It also pops the buffer in the very cycle a byte is written, where a design that lost the write would show an empty buffer, or valid low with full high. It checks that arbitration loss, abort and a disable all free SCL, because a design that kept holding it would stall the master until the watchdog expired.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX_WAIT,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic expire;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_BITS-1:0] first_byte,
                                      input logic [ADDR_BITS-1:0] own);
        return first_byte[BYTE_BITS-1:1] == own;
    endfunction

endpackage

// File: rtl/i2ct_bus_mon.sv
module i2ct_bus_mon
    import i2ct_pkg::*;
#(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl,
    input  logic            sda,
    input  logic [TO_W-1:0] cfg_timeout,
    output bus_evt_t        evt,
    output logic            busy
);

    logic            scl_p, sda_p;
    logic [TO_W-1:0] idle_cnt;
    logic            any_edge, hi_prev, expire_raw;

    assign any_edge = (scl_p != scl) || (sda_p != sda);
    assign hi_prev  = scl_p && sda_p;

    assign evt.start    = scl_p && scl && sda_p && !sda;
    assign evt.stop     = scl_p && scl && !sda_p && sda;
    assign evt.scl_rise = !scl_p && scl;
    assign evt.scl_fall = scl_p && !scl;

    // Expiry is judged from last cycle's line samples, so a START in this
    // cycle can be seen alongside it and take precedence.
    assign expire_raw = busy && hi_prev && (cfg_timeout != '0)
                      && (idle_cnt == cfg_timeout - 1'b1);
    assign evt.expire = expire_raw && !evt.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            idle_cnt <= '0;
            busy     <= 1'b0;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
            if (any_edge || !hi_prev || !busy || expire_raw)
                idle_cnt <= '0;
            else
                idle_cnt <= idle_cnt + 1'b1;
            if (evt.start)
                busy <= 1'b1;
            else if (evt.stop || evt.expire)
                busy <= 1'b0;
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> busy); // R3
    AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !busy); // R1
    AST_EXPIRE_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        evt.expire |=> !busy); // R2

endmodule

// File: rtl/i2ct_rxbuf.sv
module i2ct_rxbuf #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         accept,
    output logic [W-1:0] head,
    output logic         valid,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic [CNT_W-1:0] cnt;
    logic             do_pop;

    assign valid  = cnt != '0;
    assign full   = cnt == CNT_W'(DEPTH);
    assign do_pop = pop && valid;
    // A pop in the same cycle frees a slot for the incoming byte.
    assign accept = push && (!full || do_pop);
    assign head   = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wptr] <= push_data;
                wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({accept, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_RACE_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
        push && pop && valid |=> valid); // R8
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop |=> $stable(cnt)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R7

endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
    import i2ct_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 abort,
    input  logic                 go_idle,
    input  bus_evt_t             evt,
    input  logic                 sda,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 tx_valid,
    input  logic [BYTE_BITS-1:0] tx_data,
    input  logic                 accept,
    output logic                 push,
    output logic [BYTE_BITS-1:0] push_data,
    output logic                 arb_lost,
    output logic                 sda_oe,
    output logic                 scl_oe
);

    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    tgt_state_e           state;
    logic [3:0]           bitcnt;
    logic [BYTE_BITS-1:0] sh;
    logic                 rw, nack, kill, live;

    assign kill = !en || abort || evt.stop || (go_idle && evt.expire);
    assign live = !kill && !evt.start;

    assign push      = live && (state == ST_RX) && evt.scl_fall && (bitcnt == LAST_BIT);
    assign push_data = sh;
    assign arb_lost  = live && (state == ST_TX) && evt.scl_rise && !sda_oe && !sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sh     <= '0;
            rw     <= 1'b0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (kill) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (evt.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (evt.scl_rise && bitcnt != LAST_BIT) begin
                        sh     <= {sh[BYTE_BITS-2:0], sda};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (evt.scl_fall && bitcnt == LAST_BIT) begin
                        if (addr_hit(sh, own_addr)) begin
                            sda_oe <= 1'b1;
                            rw     <= sh[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: if (evt.scl_fall) begin
                    sda_oe <= 1'b0;
                    bitcnt <= '0;
                    if (rw) begin
                        scl_oe <= 1'b1;
                        state  <= ST_TX_WAIT;
                    end else begin
                        state <= ST_RX;
                    end
                end
                ST_RX: begin
                    if (evt.scl_rise && bitcnt != LAST_BIT) begin
                        sh     <= {sh[BYTE_BITS-2:0], sda};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (evt.scl_fall && bitcnt == LAST_BIT) begin
                        sda_oe <= accept;
                        state  <= ST_RX_ACK;
                    end
                end
                ST_RX_ACK: if (evt.scl_fall) begin
                    sda_oe <= 1'b0;
                    bitcnt <= '0;
                    state  <= ST_RX;
                end
                ST_TX_WAIT: if (tx_valid) begin
                    sh     <= tx_data;
                    sda_oe <= !tx_data[BYTE_BITS-1];
                    scl_oe <= 1'b0;
                    bitcnt <= '0;
                    state  <= ST_TX;
                end
                ST_TX: begin
                    if (arb_lost) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        if (evt.scl_rise)
                            bitcnt <= bitcnt + 1'b1;
                        if (evt.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                sh     <= {sh[BYTE_BITS-2:0], 1'b0};
                                sda_oe <= !sh[BYTE_BITS-2];
                            end
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (evt.scl_rise)
                        nack <= sda;
                    if (evt.scl_fall) begin
                        if (nack) begin
                            state <= ST_IDLE;
                        end else begin
                            scl_oe <= 1'b1;
                            state  <= ST_TX_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ABORT_FREES_LINES: assert property (@(posedge clk) disable iff (rst)
        abort |=> !sda_oe && !scl_oe); // R12
    AST_ARB_FREES_LINES: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> !sda_oe && !scl_oe && state == ST_IDLE); // R11
    AST_GO_IDLE: assert property (@(posedge clk) disable iff (rst)
        en && go_idle && evt.expire |=> state == ST_IDLE); // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sda_oe && !scl_oe); // R13
    AST_ACK_ONLY_AFTER_EIGHT: assert property (@(posedge clk) disable iff (rst)
        state == ST_ADDR && evt.scl_fall && bitcnt != LAST_BIT |=> !sda_oe); // R5
    AST_STRETCH_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> state == ST_TX_WAIT); // R10

endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int TO_W     = 8,
    parameter int RX_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 scl_oe,
    output logic                 sda_oe,
    input  logic                 cfg_en,
    input  logic [ADDR_BITS-1:0] cfg_addr,
    input  logic [TO_W-1:0]      cfg_timeout,
    input  logic                 cfg_go_idle,
    input  logic                 cmd_abort,
    input  logic                 flag_clr,
    input  logic                 tx_valid,
    input  logic [BYTE_BITS-1:0] tx_data,
    input  logic                 rx_pop,
    output logic [BYTE_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_full,
    output logic                 bus_busy,
    output logic                 flag_timeout,
    output logic                 flag_arblost
);

    bus_evt_t             evt;
    logic                 push, accept, arb_lost;
    logic [BYTE_BITS-1:0] push_data;

    i2ct_bus_mon #(.TO_W(TO_W)) u_mon (
        .clk         (clk),
        .rst         (rst),
        .scl         (scl_i),
        .sda         (sda_i),
        .cfg_timeout (cfg_timeout),
        .evt         (evt),
        .busy        (bus_busy)
    );

    i2ct_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_en),
        .abort     (cmd_abort),
        .go_idle   (cfg_go_idle),
        .evt       (evt),
        .sda       (sda_i),
        .own_addr  (cfg_addr),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .accept    (accept),
        .push      (push),
        .push_data (push_data),
        .arb_lost  (arb_lost),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    i2ct_rxbuf #(.DEPTH(RX_DEPTH), .W(BYTE_BITS)) u_rxbuf (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (rx_pop),
        .accept    (accept),
        .head      (rx_data),
        .valid     (rx_valid),
        .full      (rx_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_timeout <= 1'b0;
            flag_arblost <= 1'b0;
        end else begin
            if (evt.expire)    flag_timeout <= 1'b1;
            else if (flag_clr) flag_timeout <= 1'b0;
            if (arb_lost)      flag_arblost <= 1'b1;
            else if (flag_clr) flag_arblost <= 1'b0;
        end
    end

    AST_ARB_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> flag_arblost); // R11
    AST_TIMEOUT_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        evt.expire |=> flag_timeout); // R2

endmodule

// File: tb/tb_i2ct_target.sv
module tb_i2ct_target;

    localparam int TO_W = 8;
    localparam logic [6:0] OWN = 7'h3A;
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe;
    logic cfg_en = 1'b1, cfg_go_idle = 1'b0, cmd_abort = 1'b0, flag_clr = 1'b0;
    logic [6:0] cfg_addr = OWN;
    logic [TO_W-1:0] cfg_timeout = TO_W'(LIM);
    logic tx_valid = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic rx_valid, rx_full, bus_busy, flag_timeout, flag_arblost;

    wire scl_ln = scl_m & ~scl_oe;
    wire sda_ln = sda_m & ~sda_oe;

    i2ct_target #(.TO_W(TO_W), .RX_DEPTH(2)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_ln), .sda_i(sda_ln),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
        .cfg_timeout(cfg_timeout), .cfg_go_idle(cfg_go_idle), .cmd_abort(cmd_abort),
        .flag_clr(flag_clr), .tx_valid(tx_valid), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full), .bus_busy(bus_busy),
        .flag_timeout(flag_timeout), .flag_arblost(flag_arblost)
    );

    int checks = 0;
    int failures = 0;

    // {address, data byte, address expected to match}
    localparam logic [15:0] VECS [4] = '{
        {7'h3A, 8'h5C, 1'b1},
        {7'h3A, 8'h00, 1'b1},
        {7'h12, 8'hFF, 1'b0},
        {7'h3A, 8'hE7, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (4) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic m_bit(input logic b, input logic pop_at_fall, input int hold,
                         output logic s);
        sda_m = b; hp();
        scl_m = 1'b1;
        while (scl_ln !== 1'b1) @(negedge clk);
        hp();
        repeat (hold) @(negedge clk);
        s = sda_ln;
        scl_m = 1'b0;
        if (pop_at_fall) begin
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            hp();
        end
    endtask

    task automatic m_wbyte(input logic [7:0] b, input logic pop_last, input int hold,
                           output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--)
            m_bit(b[i], (i == 0) && pop_last, (i == 7) ? hold : 0, s);
        m_bit(1'b1, 1'b0, 0, ack);
    endtask

    task automatic m_rbyte(input logic ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, 1'b0, 0, s);
            d[i] = s;
        end
        m_bit(ack, 1'b0, 0, s);
    endtask

    task automatic pop_one();
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
    endtask

    task automatic supply(input logic [7:0] b);
        tx_data = b; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", bus_busy, 0);
        chk("R7 valid after reset", rx_valid, 0);
        chk("R12 lines free after reset", {scl_oe, sda_oe}, 0);

        // Table of write transfers
        for (int i = 0; i < 4; i++) begin
            m_start();
            chk("R1 busy after START", bus_busy, 1);
            m_wbyte({VECS[i][15:9], 1'b0}, 1'b0, 0, a);
            chk("R5 address ack", a, !VECS[i][0]);
            if (VECS[i][0]) begin
                m_wbyte(VECS[i][8:1], 1'b0, 0, a);
                chk("R6 data ack", a, 0);
            end
            m_stop();
            chk("R1 idle after STOP", bus_busy, 0);
            chk("R6 stored", rx_valid, VECS[i][0]);
            if (VECS[i][0]) begin
                chk("R6 stored value", rx_data, VECS[i][8:1]);
                pop_one();
            end
        end

        // R5: SDA moves while SCL low before the first address clock
        m_start();
        sda_m = 1'b1; hp(); sda_m = 1'b0; hp();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        chk("R5 ack slot kept after early SDA fall", a, 0);
        m_wbyte(8'h96, 1'b0, 0, a);
        m_stop();
        chk("R5 byte not shifted", rx_data, 8'h96);
        pop_one();

        // R7/R9: fill, then overflow is NACKed and dropped
        m_start();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        m_wbyte(8'h01, 1'b0, 0, a);
        m_wbyte(8'h02, 1'b0, 0, a);
        chk("R7 full with two", {rx_valid, rx_full}, 2'b11);
        m_wbyte(8'h03, 1'b0, 0, a);
        chk("R9 NACK when full", a, 1);
        m_stop();
        chk("R7 oldest first", rx_data, 8'h01);
        pop_one();
        chk("R7 one left", {rx_valid, rx_full}, 2'b10);
        chk("R9 second kept, third dropped", rx_data, 8'h02);
        pop_one();
        chk("R7 empty", {rx_valid, rx_full}, 2'b00);

        // R8: pop in the same cycle as the write
        m_start();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        m_wbyte(8'hAA, 1'b0, 0, a);
        m_wbyte(8'hBB, 1'b1, 0, a);
        chk("R8 ack on race", a, 0);
        m_stop();
        chk("R8 flags after race", {rx_valid, rx_full}, 2'b10);
        chk("R8 new byte kept", rx_data, 8'hBB);
        pop_one();

        // R2: timeout during a long high bit, transfer continues
        m_start();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        m_wbyte(8'h80, 1'b0, 2 * LIM, a);
        chk("R2 timeout flag", flag_timeout, 1);
        chk("R2 busy cleared", bus_busy, 0);
        chk("R4 no go-idle keeps ack", a, 0);
        m_stop();
        chk("R4 no go-idle keeps byte", rx_data, 8'h80);
        pop_one();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
        chk("R2 flag cleared", flag_timeout, 0);

        // R4: go-idle, and R2 fires again after clear
        cfg_go_idle = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        m_wbyte(8'h81, 1'b0, 2 * LIM, a);
        chk("R2 fires again", flag_timeout, 1);
        chk("R4 go-idle NACK", a, 1);
        m_stop();
        chk("R4 go-idle nothing stored", rx_valid, 0);
        cfg_go_idle = 1'b0;
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

        // R3: START in the exact expiry cycle
        m_start();
        sda_m = 1'b1; hp();
        scl_m = 1'b1;
        repeat (LIM) @(negedge clk);
        sda_m = 1'b0;
        hp();
        chk("R3 START wins: busy", bus_busy, 1);
        chk("R3 START wins: no flag", flag_timeout, 0);
        scl_m = 1'b0; hp();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        chk("R13 new START restarts address", a, 0);
        m_wbyte(8'h3C, 1'b0, 0, a);
        m_stop();
        chk("R13 byte after restart", rx_data, 8'h3C);
        pop_one();

        // R13: enable toggle mid-transfer
        m_start();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        cfg_en = 1'b0; @(negedge clk);
        chk("R13 lines free when disabled", {scl_oe, sda_oe}, 0);
        cfg_en = 1'b1; @(negedge clk);
        m_wbyte(8'h44, 1'b0, 0, a);
        chk("R13 idle after toggle NACKs", a, 1);
        m_start();
        m_wbyte({OWN, 1'b0}, 1'b0, 0, a);
        chk("R13 address after re-enable", a, 0);
        m_stop();
        chk("R13 nothing stored", rx_valid, 0);

        // R10: read with stretch
        m_start();
        m_wbyte({OWN, 1'b1}, 1'b0, 0, a);
        chk("R5 read address ack", a, 0);
        chk("R10 SCL stretched", scl_oe, 1);
        scl_m = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 SCL held low", scl_ln, 0);
        supply(8'hA5);
        m_rbyte(1'b0, d);
        chk("R10 first byte", d, 8'hA5);
        chk("R10 stretch again after ACK", scl_oe, 1);
        supply(8'h3E);
        m_rbyte(1'b1, d);
        chk("R10 second byte", d, 8'h3E);
        chk("R10 released after NACK", scl_oe, 0);
        m_stop();

        // R11: arbitration loss on a 1 bit
        m_start();
        m_wbyte({OWN, 1'b1}, 1'b0, 0, a);
        sda_m = 1'b0; scl_m = 1'b1;
        supply(8'hC0);
        hp();
        chk("R11 arb flag", flag_arblost, 1);
        chk("R11 lines free", {scl_oe, sda_oe}, 0);
        scl_m = 1'b0; hp();
        m_stop();

        // R12: abort while stretching
        m_start();
        m_wbyte({OWN, 1'b1}, 1'b0, 0, a);
        chk("R12 stretching before abort", scl_oe, 1);
        cmd_abort = 1'b1; @(negedge clk); cmd_abort = 1'b0;
        chk("R12 lines free after abort", {scl_oe, sda_oe}, 0);
        m_stop();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule